// File: doc/BRIEF.md
# Parallel Port Extended Register Window with Test FIFO

This block is the extended-capabilities register window of a parallel port. It sits behind its own eight-byte I/O window, and only the low three address bits reach it. The window holds three registers. The extended control register carries a 3-bit operating-mode field, three free bits and a 2-bit FIFO status code. Configuration B is a plain byte register. The third is a data location at offset 0.

The data location at offset 0 changes meaning with the mode. In FIFO test mode it is the face of a small byte FIFO: a write pushes a byte and a read pops one. In every other mode it is an ordinary holding register. A write to the extended control register that changes the mode flushes the FIFO first.

The mode register is the block's state machine. Its eight states are `MODE_STD`, `MODE_BYTE`, `MODE_PFIFO`, `MODE_XFIFO`, `MODE_EPP`, `MODE_RSVD`, `MODE_TEST` and `MODE_CFG`. There is a single transition, `T_ECR_WRITE`, which moves from any state to the state named in bits 7:5 of the write. When that state differs from the current one, the transition also performs `T_FLUSH`. The FIFO reacts to bus traffic only in `MODE_TEST`.

Top module: `pport_ext_regs`

## Requirements
- R1: After reset, offset 2 reads 0x01 (mode 0, status empty), and offsets 1 and 0 read 0x00.
- R2: Offset 2 holds the mode in bits 7:5, with codes 0 standard, 1 byte, 2 port FIFO, 3 extended FIFO, 4 EPP, 5 reserved, 6 FIFO test, 7 configuration. A write replaces the mode and stores bits 4:2 as written. Bits 1:0 of the write are ignored. The mode changes only through such a write.
- R3: Bits 1:0 of offset 2 give the FIFO status: 01 empty, 10 full (two bytes), 00 partly filled. The code 11 never appears.
- R4: In mode 6, a write to offset 0 pushes a byte and a read from offset 0 pops the oldest byte. Both pointers wrap after the last entry, so bytes leave in the order they entered.
- R5: A push when full is ignored. A pop when empty returns 0xFF. Neither changes the FIFO.
- R6: A write to offset 2 with a different mode empties the FIFO. A write that keeps the same mode leaves the FIFO contents in place.
- R7: Outside mode 6, offset 0 is a holding register that keeps its value across FIFO test traffic, and the FIFO does not change.
- R8: Offset 1 is a read/write byte register.
- R9: Offsets 3 to 7 read 0xFF, and writes to them change no register.
- R10: A cycle with both the write and read strobes acts as a write only. No pop takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset (low address bits) |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access; pops in mode 6 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid in the strobe cycle |

## Verification
The bench builds the block with its default FIFO depth of two. At that depth a third push already runs into the full condition, and a pop followed by one more push drives the write pointer past its wrap point while the read pointer is still behind it. All status codes, both ignored-access cases and the wrap ordering therefore fit into a few dozen accesses. The bench also visits mode changes out of the test mode and into it, as well as a rewrite of the same mode.

// File: rtl/pport_ext_pkg.sv
package pport_ext_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;
    localparam int N_OFS  = 1 << OFS_W;

    localparam int OFS_DATA = 0;
    localparam int OFS_CFGB = 1;
    localparam int OFS_ECR  = 2;

    localparam logic [BYTE_W-1:0] IDLE_READ = 8'hFF;

    typedef enum logic [2:0] {
        MODE_STD   = 3'd0,
        MODE_BYTE  = 3'd1,
        MODE_PFIFO = 3'd2,
        MODE_XFIFO = 3'd3,
        MODE_EPP   = 3'd4,
        MODE_RSVD  = 3'd5,
        MODE_TEST  = 3'd6,
        MODE_CFG   = 3'd7
    } xmode_e;

endpackage

// File: rtl/pport_ext_decode.sv
module pport_ext_decode
    import pport_ext_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [N_OFS-1:0] wr_sel,
    output logic [N_OFS-1:0] rd_sel
);

    // Write wins over read when both strobes are present (R10)
    logic rd_only;
    assign rd_only = rd_en & ~wr_en;

    for (genvar g = 0; g < N_OFS; g++) begin : g_sel
        assign wr_sel[g] = wr_en   & (addr == OFS_W'(g));
        assign rd_sel[g] = rd_only & (addr == OFS_W'(g));
    end

endmodule

// File: rtl/pport_ext_fifo.sv
module pport_ext_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic                           pop,
    input  logic                           flush,
    input  logic [W-1:0]                   din,
    output logic [W-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]     fill,
    output logic                           empty,
    output logic                           full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rd_ptr];
    assign fill    = cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/pport_ext_regs.sv
module pport_ext_regs
    import pport_ext_pkg::*;
#(
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [N_OFS-1:0]  wr_sel, rd_sel;
    xmode_e            mode_q, mode_d;
    logic [2:0]        ecr_free_q;
    logic [BYTE_W-1:0] cfgb_q, hold_q;
    logic              flush, push, pop, in_test;
    logic [BYTE_W-1:0] head;
    logic [CNT_W-1:0]  fill;
    logic              f_empty, f_full;
    logic [BYTE_W-1:0] data0_rd;

    pport_ext_decode u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    // Next mode: T_ECR_WRITE moves to the written mode; T_FLUSH rides along
    always_comb begin
        mode_d = mode_q;
        flush  = 1'b0;
        if (wr_sel[OFS_ECR]) begin
            mode_d = xmode_e'(wdata[7:5]);
            flush  = (wdata[7:5] != mode_q);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STD;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Outputs of the state: what offset 0 means in each mode
    always_comb begin
        in_test  = 1'b0;
        data0_rd = hold_q;
        unique case (mode_q)
            MODE_TEST: begin
                in_test  = 1'b1;
                data0_rd = f_empty ? IDLE_READ : head;
            end
            MODE_STD, MODE_BYTE, MODE_PFIFO, MODE_XFIFO,
            MODE_EPP, MODE_RSVD, MODE_CFG: begin
                in_test  = 1'b0;
                data0_rd = hold_q;
            end
        endcase
    end

    assign push = in_test & wr_sel[OFS_DATA];
    assign pop  = in_test & rd_sel[OFS_DATA];

    pport_ext_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (BYTE_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .din   (wdata),
        .head  (head),
        .fill  (fill),
        .empty (f_empty),
        .full  (f_full)
    );

    // Plain registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecr_free_q <= '0;
            cfgb_q     <= '0;
            hold_q     <= '0;
        end else begin
            if (wr_sel[OFS_ECR])                 ecr_free_q <= wdata[4:2];
            if (wr_sel[OFS_CFGB])                cfgb_q     <= wdata;
            if (wr_sel[OFS_DATA] && !in_test)    hold_q     <= wdata;
        end
    end

    // Read mux
    always_comb begin
        case (addr)
            OFS_W'(OFS_DATA): rdata = data0_rd;
            OFS_W'(OFS_CFGB): rdata = cfgb_q;
            OFS_W'(OFS_ECR):  rdata = {mode_q, ecr_free_q, f_full, f_empty};
            default:          rdata = IDLE_READ;
        endcase
    end

endmodule

// File: rtl/pport_ext_checker.sv
module pport_ext_checker #(
    parameter int FIFO_DEPTH = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [2:0]                     addr,
    input logic                           wr_en,
    input logic                           rd_en,
    input logic [7:0]                     wdata,
    input logic [7:0]                     rdata,
    input logic [2:0]                     mode_q,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fill,
    input logic                           f_empty,
    input logic                           f_full
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    p_status_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_full && f_empty));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(FIFO_DEPTH));

    p_mode_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd2) |=> $stable(mode_q));

    p_flush_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && wdata[7:5] != mode_q) |=> (fill == '0));

    p_push_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && mode_q == 3'd6 && !f_full)
        |=> (fill == $past(fill) + 1'b1));

    p_pop_empty_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd0 && mode_q == 3'd6 && f_empty)
        |-> (rdata == 8'hFF));

    p_fifo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 3'd6 && !(wr_en && addr == 3'd2)) |=> $stable(fill));

    p_unused_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 3'd3) |-> (rdata == 8'hFF));

    p_both_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && addr == 3'd0 && mode_q == 3'd6 && f_full)
        |=> $stable(fill));

endmodule

bind pport_ext_regs pport_ext_checker #(.FIFO_DEPTH(FIFO_DEPTH)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .mode_q  (mode_q),
    .fill    (fill),
    .f_empty (f_empty),
    .f_full  (f_full)
);

// File: tb/test_pport_ext_regs.sv
`timescale 1ns/1ps
module test_pport_ext_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pport_ext_regs #(.FIFO_DEPTH(2)) i_pport_ext_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    // {read?, requirement, offset, write data or expected read}
    localparam int NV = 46;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {1'b1, 4'd1,  3'd2, 8'h01},  // R1 ECR after reset
        {1'b1, 4'd1,  3'd1, 8'h00},  // R1 config B after reset
        {1'b1, 4'd1,  3'd0, 8'h00},  // R1 holding after reset
        {1'b0, 4'd7,  3'd0, 8'hA5},
        {1'b1, 4'd7,  3'd0, 8'hA5},  // R7 holding register
        {1'b0, 4'd8,  3'd1, 8'h3C},
        {1'b1, 4'd8,  3'd1, 8'h3C},  // R8 config B
        {1'b0, 4'd2,  3'd2, 8'hDF},  // mode 6, free bits 111, low bits dropped
        {1'b1, 4'd2,  3'd2, 8'hDD},  // R2
        {1'b1, 4'd5,  3'd0, 8'hFF},  // R5 pop on empty
        {1'b1, 4'd5,  3'd2, 8'hDD},  // R5 still empty
        {1'b0, 4'd4,  3'd0, 8'h11},
        {1'b1, 4'd3,  3'd2, 8'hDC},  // R3 partly filled
        {1'b0, 4'd4,  3'd0, 8'h22},
        {1'b1, 4'd3,  3'd2, 8'hDE},  // R3 full
        {1'b0, 4'd5,  3'd0, 8'h33},  // push when full
        {1'b1, 4'd5,  3'd2, 8'hDE},  // R5 still full
        {1'b1, 4'd4,  3'd0, 8'h11},  // R4 oldest first
        {1'b1, 4'd3,  3'd2, 8'hDC},  // R3
        {1'b0, 4'd4,  3'd0, 8'h44},  // write pointer wraps
        {1'b1, 4'd4,  3'd2, 8'hDE},  // R4
        {1'b1, 4'd4,  3'd0, 8'h22},  // R4
        {1'b1, 4'd4,  3'd0, 8'h44},  // R4 read pointer wrapped
        {1'b1, 4'd3,  3'd2, 8'hDD},  // R3 empty again
        {1'b1, 4'd5,  3'd0, 8'hFF},  // R5
        {1'b0, 4'd6,  3'd0, 8'h55},
        {1'b0, 4'd6,  3'd2, 8'hC0},  // same mode rewrite
        {1'b1, 4'd6,  3'd2, 8'hC0},  // R6 no flush
        {1'b1, 4'd6,  3'd0, 8'h55},  // R6 contents kept
        {1'b0, 4'd6,  3'd0, 8'h66},
        {1'b0, 4'd6,  3'd2, 8'h20},  // change to mode 1
        {1'b1, 4'd6,  3'd2, 8'h21},  // R6 flushed
        {1'b1, 4'd7,  3'd0, 8'hA5},  // R7 holding survived test traffic
        {1'b0, 4'd7,  3'd0, 8'h77},
        {1'b0, 4'd7,  3'd2, 8'hC0},
        {1'b1, 4'd7,  3'd2, 8'hC1},  // R7 mode 1 write did not push
        {1'b1, 4'd7,  3'd0, 8'hFF},  // R7
        {1'b0, 4'd2,  3'd2, 8'h00},
        {1'b1, 4'd2,  3'd2, 8'h01},  // R2
        {1'b1, 4'd7,  3'd0, 8'h77},  // R7
        {1'b0, 4'd9,  3'd3, 8'h99},
        {1'b1, 4'd9,  3'd3, 8'hFF},  // R9
        {1'b1, 4'd9,  3'd7, 8'hFF},  // R9
        {1'b1, 4'd9,  3'd1, 8'h3C},  // R9 config B untouched
        {1'b0, 4'd2,  3'd2, 8'hE0},
        {1'b1, 4'd2,  3'd2, 8'hE1}   // R2 mode 7
    };

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        n_checks++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d: offset %0d read %h expected %h", req, a, rdata, exp);
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][15]) do_rd(VEC[i][10:8], VEC[i][7:0], int'(VEC[i][14:11]));
            else            do_wr(VEC[i][10:8], VEC[i][7:0]);
        end

        // R10: both strobes in one cycle act as a write only
        do_wr(3'd2, 8'hC0);
        do_wr(3'd0, 8'h88);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h99; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        do_rd(3'd2, 8'hC2, 10);  // R10 full, no pop
        do_rd(3'd0, 8'h88, 10);  // R10
        do_rd(3'd0, 8'h99, 10);  // R10

        // R1: reset in mid-run restores every register
        do_wr(3'd1, 8'h5A);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_rd(3'd2, 8'h01, 1);   // R1
        do_rd(3'd1, 8'h00, 1);   // R1
        do_rd(3'd0, 8'h00, 1);   // R1

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule